// File: doc/BRIEF.md
# Bit-Field Extract and Insert Unit

This block is the bit-field datapath of a 32-bit processor execute stage. A one-bit operation select picks one of two operations. Extract takes a field out of a source word and returns it right-justified at bit 0, with zeros above it. Insert writes the low-order bits of a source word into a chosen bit range of an existing destination word and leaves every other destination bit as it was.

The two operations read their 5-bit immediates differently. For extract, the first immediate is the field width. For insert, it is the index of the field's top bit, which equals width + offset − 1. The second immediate is always the bit offset of the field's lowest bit. The result mask is therefore built from the range [0, width−1] for extract and from [offset, top] for insert.

An illegal-field flag reports a specification that cannot be honoured. The result can be taken straight from the combinational logic or from one registered stage. The stage is chosen by a parameter and its register loads only when the input is marked valid.

Top module: `bfu_top`

## Requirements
- R1: Operation select 0 is extract. The result equals (src >> offset) with every bit at index ≥ width cleared.
- R2: An extract with width 0 yields an all-zero result.
- R3: For extract, the illegal flag is high exactly when width + offset > 32. The result is still the shifted, masked value.
- R4: Operation select 1 is insert, with top ≥ offset. Result bits offset..top take src bits 0..(top−offset), and every other bit equals dst.
- R5: For insert with top < offset, the illegal flag is high and the result equals dst unchanged.
- R6: For a legal specification of either operation, the illegal flag is low.
- R7: With the registered stage enabled (default), result, flag and valid out update one clock after valid_i is high. Result and flag hold their values while valid_i is low, and valid_o follows valid_i with one cycle of delay.
- R8: During reset, res_o, bad_o and valid_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operands valid; load enable for the output stage |
| op_i | input | 1 | 0 = extract, 1 = insert |
| imm_a_i | input | 5 | Extract: field width; insert: top bit index |
| imm_b_i | input | 5 | Bit offset of the field's lowest bit |
| src_i | input | 32 | Source operand |
| dst_i | input | 32 | Previous destination value (used by insert) |
| res_o | output | 32 | Result |
| bad_o | output | 1 | Illegal field specification |
| valid_o | output | 1 | Result valid |

## Verification
The assertions assume that op_i, both immediates and both operands hold known values in every cycle after reset, because the combinational checks look at the next-state result in every cycle and not only when valid_i is high. The stimulus drives every input to a defined value before reset is released. It changes inputs only on the falling clock edge, so each operand set is stable across the rising edge that loads it. Legal extract and insert (width, offset) pairs are swept exhaustively with random operands. Illegal pairs and hold cycles are added as directed cases.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  localparam int unsigned BFU_DATA_W = 32;
  localparam int unsigned BFU_IMM_W  = $clog2(BFU_DATA_W);

  typedef enum logic {
    BFU_OP_EXTRACT = 1'b0,
    BFU_OP_INSERT  = 1'b1
  } bfu_op_e;
endpackage

// File: rtl/bfu_range_mask.sv
module bfu_range_mask #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IMM_W = $clog2(DATA_W)
) (
  input  logic              en_i,
  input  logic [IMM_W-1:0]  lo_i,
  input  logic [IMM_W-1:0]  hi_i,
  output logic [DATA_W-1:0] mask_o
);
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_bit
    localparam logic [IMM_W-1:0] IDX = IMM_W'(gi);
    assign mask_o[gi] = en_i && (IDX >= lo_i) && (IDX <= hi_i);
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IMM_W = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]  width_i,
  input  logic [IMM_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] src_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bad_o
);
  logic [DATA_W-1:0] keep_mask;
  logic [DATA_W-1:0] aligned;
  logic [IMM_W:0]    span;

  bfu_range_mask #(.DATA_W(DATA_W)) u_mask (
    .en_i   (width_i != '0),
    .lo_i   ('0),
    .hi_i   (width_i - IMM_W'(1)),
    .mask_o (keep_mask)
  );

  always_comb begin
    aligned = src_i >> ofs_i;
    res_o   = aligned & keep_mask;
    span    = {1'b0, width_i} + {1'b0, ofs_i};
    bad_o   = span > (IMM_W+1)'(DATA_W);
  end
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IMM_W = $clog2(DATA_W)
) (
  input  logic [IMM_W-1:0]  top_i,
  input  logic [IMM_W-1:0]  ofs_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bad_o
);
  logic [DATA_W-1:0] fld_mask;
  logic [DATA_W-1:0] placed;

  bfu_range_mask #(.DATA_W(DATA_W)) u_mask (
    .en_i   (1'b1),
    .lo_i   (ofs_i),
    .hi_i   (top_i),
    .mask_o (fld_mask)
  );

  always_comb begin
    placed = src_i << ofs_i;
    bad_o  = top_i < ofs_i;
    if (bad_o) res_o = dst_i;
    else       res_o = (dst_i & ~fld_mask) | (placed & fld_mask);
  end
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter bit          REG_OUT = 1'b1,
  localparam int unsigned IMM_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic              op_i,
  input  logic [IMM_W-1:0]  imm_a_i,
  input  logic [IMM_W-1:0]  imm_b_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              bad_o,
  output logic              valid_o
);
  bfu_op_e           op_sel;
  logic [DATA_W-1:0] ext_res, ins_res, nxt_res;
  logic              ext_bad, ins_bad, nxt_bad;

  assign op_sel = bfu_op_e'(op_i);

  bfu_extract #(.DATA_W(DATA_W)) u_ext (
    .width_i (imm_a_i),
    .ofs_i   (imm_b_i),
    .src_i   (src_i),
    .res_o   (ext_res),
    .bad_o   (ext_bad)
  );

  bfu_insert #(.DATA_W(DATA_W)) u_ins (
    .top_i (imm_a_i),
    .ofs_i (imm_b_i),
    .src_i (src_i),
    .dst_i (dst_i),
    .res_o (ins_res),
    .bad_o (ins_bad)
  );

  always_comb begin
    if (op_sel == BFU_OP_INSERT) begin
      nxt_res = ins_res;
      nxt_bad = ins_bad;
    end else begin
      nxt_res = ext_res;
      nxt_bad = ext_bad;
    end
  end

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] res_q;
    logic              bad_q;
    logic              vld_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        res_q <= '0;
        bad_q <= 1'b0;
        vld_q <= 1'b0;
      end else begin
        vld_q <= valid_i;
        if (valid_i) begin
          res_q <= nxt_res;
          bad_q <= nxt_bad;
        end
      end
    end

    assign res_o   = res_q;
    assign bad_o   = bad_q;
    assign valid_o = vld_q;

    // R7: output stage timing
    a_r7_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (valid_o == $past(valid_i)));
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(res_o) && $stable(bad_o)));
    a_r7_load: assert property (@(posedge clk) disable iff (!rst_n)
      valid_i |=> (res_o == $past(nxt_res)));
  end else begin : g_comb
    assign res_o   = nxt_res;
    assign bad_o   = nxt_bad;
    assign valid_o = valid_i;
  end

  logic [DATA_W-1:0] chk_mask;
  assign chk_mask = ({DATA_W{1'b1}} << imm_b_i) &
                    ({DATA_W{1'b1}} >> (IMM_W'(DATA_W-1) - imm_a_i));

  // R1: nothing above the extracted field survives
  a_r1_ext_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == BFU_OP_EXTRACT) |-> ((nxt_res >> imm_a_i) == '0));
  // R3: flag only for an overrunning extract field
  a_r3_ext_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == BFU_OP_EXTRACT && nxt_bad) |->
      (int'(imm_a_i) + int'(imm_b_i) > int'(DATA_W)));
  // R4: bits outside the insert field come from dst
  a_r4_ins_outside_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == BFU_OP_INSERT && imm_a_i >= imm_b_i) |->
      (((nxt_res ^ dst_i) & ~chk_mask) == '0));
  // R5: reversed insert range passes dst through and flags
  a_r5_ins_bad_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == BFU_OP_INSERT && imm_a_i < imm_b_i) |->
      (nxt_bad && nxt_res == dst_i));
  // R6: legal insert never flags
  a_r6_ins_legal: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == BFU_OP_INSERT && imm_a_i >= imm_b_i) |-> !nxt_bad);
endmodule

// File: tb/bfu_top_tb_top.sv
module bfu_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic        op_i;
  logic [4:0]  imm_a_i, imm_b_i;
  logic [31:0] src_i, dst_i;
  logic [31:0] res_o;
  logic        bad_o, valid_o;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  bfu_top dut_i (
    .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i),
    .imm_a_i(imm_a_i), .imm_b_i(imm_b_i), .src_i(src_i), .dst_i(dst_i),
    .res_o(res_o), .bad_o(bad_o), .valid_o(valid_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] exp_extract(logic [31:0] s, int w, int o);
    logic [31:0] r = '0;
    for (int i = 0; i < w; i++)
      if (o + i < 32) r[i] = s[o + i];
    return r;
  endfunction

  function automatic logic [31:0] exp_insert(logic [31:0] d, logic [31:0] s,
                                             int top, int o);
    logic [31:0] r = d;
    if (top < o) return d;
    for (int i = o; i <= top; i++) r[i] = s[i - o];
    return r;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(logic op, int a, int b, logic [31:0] s, logic [31:0] d);
    @(negedge clk);
    op_i = op; imm_a_i = 5'(a); imm_b_i = 5'(b);
    src_i = s; dst_i = d; valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
  endtask

  task automatic run_ext(int w, int o, logic [31:0] s, string req);
    issue(1'b0, w, o, s, $urandom());
    check(req, res_o, exp_extract(s, w, o));
    check(req, {31'b0, bad_o}, {31'b0, (w + o > 32)});
    check("R7", {31'b0, valid_o}, 32'd1);
  endtask

  task automatic run_ins(int top, int o, logic [31:0] s, logic [31:0] d,
                         string req);
    issue(1'b1, top, o, s, d);
    check(req, res_o, exp_insert(d, s, top, o));
    check(req, {31'b0, bad_o}, {31'b0, (top < o)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    process::self().srandom(32'h5eed_0042);
    rst_n = 1'b0; valid_i = 1'b0; op_i = 1'b0;
    imm_a_i = '0; imm_b_i = '0; src_i = '0; dst_i = '0;
    repeat (3) @(negedge clk);
    check("R8", res_o, 32'h0);
    check("R8", {30'b0, bad_o, valid_o}, 32'h0);
    rst_n = 1'b1;

    // directed corners
    run_ext(0, 7, 32'hFFFF_FFFF, "R2");
    run_ext(8, 8, 32'hDEAD_BEEF, "R1");
    run_ext(31, 1, 32'hFFFF_FFFF, "R1");
    run_ext(31, 2, 32'hFFFF_FFFF, "R3");
    run_ext(20, 20, 32'hA5A5_5A5A, "R3");
    run_ins(31, 0, 32'h1234_5678, 32'hFFFF_FFFF, "R4");
    run_ins(15, 8, 32'h0000_00AB, 32'h0000_0000, "R4");
    run_ins(31, 31, 32'h0000_0001, 32'h0000_0000, "R4");
    run_ins(3, 4, 32'hFFFF_FFFF, 32'h0BAD_F00D, "R5");
    run_ins(0, 31, 32'hFFFF_FFFF, 32'h1357_9BDF, "R5");

    // R7 hold: valid low, inputs change, output must not move
    held = res_o;
    @(negedge clk);
    op_i = 1'b0; imm_a_i = 5'd16; imm_b_i = 5'd0; src_i = 32'hCAFE_F00D;
    @(negedge clk);
    @(negedge clk);
    check("R7", res_o, held);
    check("R7", {31'b0, valid_o}, 32'd0);

    // exhaustive legal pairs with random operands (R1, R4, R6)
    for (int w = 0; w < 32; w++)
      for (int o = 0; o + w <= 32; o++)
        run_ext(w, o, $urandom(), "R6");
    for (int o = 0; o < 32; o++)
      for (int t = o; t < 32; t++)
        run_ins(t, o, $urandom(), $urandom(), "R6");

    // random mix including illegal specs
    for (int k = 0; k < 300; k++) begin
      if ($urandom_range(1, 0) == 1)
        run_ins($urandom_range(31, 0), $urandom_range(31, 0),
                $urandom(), $urandom(), "R5");
      else
        run_ext($urandom_range(31, 0), $urandom_range(31, 0),
                $urandom(), "R3");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule